// File: doc/BRIEF.md
# Fused Key Load Controller

This control engine fetches the secret content-protection keys out of the on-chip fuse macro before a link may begin authentication. A start command first looks at the power-domain status of the fuse distribution logic. If that domain is down, the engine gives up at once and makes no attempt. Otherwise it issues a load command to the fuse macro and waits for the macro's completion flag. When the flag arrives, it reads the separate result flag to decide whether the attempt worked.

A failed attempt makes the engine clear the keys and try again. A failed attempt is either a completion that reports a bad result or no completion within a timeout counted in millisecond ticks. The number of attempts is bounded. The first good attempt ends the sequence with a one-cycle command that forwards the transmitter public key to the link logic, and with a done pulse. If every attempt fails, the engine raises an error pulse.

A sticky status register records what happened, and each of its bits is cleared by writing a one to it. A separate clear command erases the keys and the fuse-related status while the engine is idle.

Top module: `keyload_ctrl`

## Requirements
- R1: After reset the status register reads 0 and fuse_req_o, key_clear_o, key_send_o, done_o and err_o are all low.
- R2: A start while pg_ok_i is low makes no load attempt, gives a one-cycle err_o and sets status bit 3 (power abort).
- R3: The sequence stops at the first attempt whose completion reports success, then pulses key_send_o and done_o once each.
- R4: Success is judged only when fuse_done_i is seen, from fuse_ok_i at that cycle; a completion with fuse_ok_i low is a failed attempt.
- R5: At most MAX_TRIES load commands are issued per start; when all fail, err_o pulses once and status bit 4 (tries exhausted) is set.
- R6: An attempt that sees TIMEOUT_MS ticks of ms_tick_i without fuse_done_i counts as failed.
- R7: Every failed attempt pulses key_clear_o once and clears status bits 0, 1, 5, 6 and 7.
- R8: Status bits are sticky: writing sts_wdata_i with sts_wr_i clears exactly the bits written as one, and a hardware set in the same cycle wins.
- R9: A start or clear command while a sequence is running is ignored and sets status bit 2 (ignored request).
- R10: A clear command while idle pulses key_clear_o once and clears status bits 0, 1, 5, 6 and 7, leaving bits 2 to 4 unchanged.
- R11: A completion sets bit 0 (load done) and bit 5 (fuse done), sets bit 1 (load ok) when fuse_ok_i is high and bit 6 (fuse error) when fuse_err_i is high; each load command sets bit 7 (fuse busy).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a key load sequence |
| clear_i | input | 1 | Request a key clear |
| pg_ok_i | input | 1 | Fuse distribution power domain is up |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| fuse_req_o | output | 1 | One-cycle load command to the fuse macro |
| fuse_done_i | input | 1 | Fuse macro reports completion |
| fuse_ok_i | input | 1 | Load result, valid with fuse_done_i |
| fuse_err_i | input | 1 | Fuse error flag, valid with fuse_done_i |
| key_clear_o | output | 1 | One-cycle command to erase the keys |
| key_send_o | output | 1 | One-cycle command to forward the public key |
| sts_wr_i | input | 1 | Write strobe for the status register |
| sts_wdata_i | input | 8 | Write-one-to-clear mask |
| sts_o | output | 8 | Sticky status register |
| done_o | output | 1 | Sequence finished with loaded keys |
| err_o | output | 1 | Sequence aborted or all attempts failed |

## Verification
The bench keeps MAX_TRIES at its default of 5. It shortens TIMEOUT_MS to 3 and drives ms_tick_i every fourth cycle, so one timed-out attempt costs about a dozen cycles. With these values, five timed-out attempts in a row, success on the fifth and last attempt, and full exhaustion all finish within a few hundred cycles. A fuse model in the bench answers load commands from a per-case script that sets how many attempts fail and whether each failure is a bad result or silence.

// File: rtl/keyload_pkg.sv
package keyload_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RETRY = 2'd2
    } seq_state_e;

    localparam int STS_W       = 8;
    localparam int SB_LD_DONE  = 0;
    localparam int SB_LD_OK    = 1;
    localparam int SB_IGNORED  = 2;
    localparam int SB_PG_ABORT = 3;
    localparam int SB_EXHAUST  = 4;
    localparam int SB_FZ_DONE  = 5;
    localparam int SB_FZ_ERR   = 6;
    localparam int SB_FZ_BUSY  = 7;

    localparam logic [STS_W-1:0] FUSE_CLR_MASK =
        (STS_W'(1) << SB_LD_DONE) | (STS_W'(1) << SB_LD_OK) |
        (STS_W'(1) << SB_FZ_DONE) | (STS_W'(1) << SB_FZ_ERR) |
        (STS_W'(1) << SB_FZ_BUSY);

endpackage

// File: rtl/keyload_tmr.sv
module keyload_tmr #(
    parameter int unsigned TIMEOUT_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TIMEOUT_MS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t d, q;

    always_comb begin
        d = q;
        if (restart_i) begin
            d.cnt = '0;
        end else if (run_i && tick_i && q.cnt != CNT_W'(TIMEOUT_MS)) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = (q.cnt == CNT_W'(TIMEOUT_MS));

    // R6: without a tick nothing moves the window
    assert_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !tick_i) |=> $stable(expired_o));
    // R6: a fresh attempt never starts already expired
    assert_restart_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expired_o);

endmodule

// File: rtl/keyload_sts.sv
module keyload_sts
    import keyload_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [STS_W-1:0] wdata_i,
    input  logic             hw_clr_i,
    input  logic [STS_W-1:0] set_i,
    output logic [STS_W-1:0] sts_o
);
    typedef struct packed {
        logic [STS_W-1:0] bits;
    } sts_regs_t;

    sts_regs_t d, q;
    logic [STS_W-1:0] drop;

    always_comb begin
        drop = (wr_i ? wdata_i : '0) | (hw_clr_i ? FUSE_CLR_MASK : '0);
        d = q;
        d.bits = (q.bits & ~drop) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts_o = q.bits;

    // R8: a bit falls only when software or the key clear drops it
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !hw_clr_i) |=> ((~sts_o & $past(sts_o)) == '0));
    // R8: a hardware set survives a simultaneous write-one-to-clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));
    // R10: the key clear leaves the event bits 2..4 alone
    assert_clear_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_i && !wr_i && set_i == '0) |=> (sts_o[4:2] == $past(sts_o[4:2])));

endmodule

// File: rtl/keyload_seq.sv
module keyload_seq
    import keyload_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             pg_ok_i,
    input  logic             fuse_done_i,
    input  logic             fuse_ok_i,
    input  logic             fuse_err_i,
    input  logic             expired_i,
    output logic             fuse_req_o,
    output logic             key_clear_o,
    output logic             key_send_o,
    output logic             done_o,
    output logic             err_o,
    output logic             restart_o,
    output logic             waiting_o,
    output logic             busy_o,
    output logic [STS_W-1:0] set_o
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [TRY_W-1:0] tries;
        logic             req;
        logic             clr;
        logic             send;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      fail;

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.clr    = 1'b0;
        d.send   = 1'b0;
        d.done   = 1'b0;
        d.err    = 1'b0;
        set_o    = '0;
        restart_o = 1'b0;
        fail     = 1'b0;

        if (q.state != ST_IDLE && (start_i || clear_i)) set_o[SB_IGNORED] = 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!pg_ok_i) begin
                        d.err = 1'b1;
                        set_o[SB_PG_ABORT] = 1'b1;
                    end else begin
                        d.req     = 1'b1;
                        d.tries   = TRY_W'(1);
                        d.state   = ST_WAIT;
                        restart_o = 1'b1;
                    end
                end else if (clear_i) begin
                    d.clr = 1'b1;
                end
            end
            ST_WAIT: begin
                if (fuse_done_i) begin
                    set_o[SB_LD_DONE] = 1'b1;
                    set_o[SB_FZ_DONE] = 1'b1;
                    set_o[SB_LD_OK]   = fuse_ok_i;
                    set_o[SB_FZ_ERR]  = fuse_err_i;
                    if (fuse_ok_i) begin
                        d.send  = 1'b1;
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        fail = 1'b1;
                    end
                end else if (expired_i) begin
                    fail = 1'b1;
                end
                if (fail) begin
                    d.clr = 1'b1;
                    if (q.tries == TRY_W'(MAX_TRIES)) begin
                        d.err = 1'b1;
                        set_o[SB_EXHAUST] = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_RETRY;
                    end
                end
            end
            ST_RETRY: begin
                d.req     = 1'b1;
                d.tries   = q.tries + TRY_W'(1);
                d.state   = ST_WAIT;
                restart_o = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign fuse_req_o  = q.req;
    assign key_clear_o = q.clr;
    assign key_send_o  = q.send;
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign waiting_o   = (q.state == ST_WAIT);
    assign busy_o      = (q.state != ST_IDLE);

    // R2: power domain down means error and no load command
    assert_pg_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i && !pg_ok_i) |=> (err_o && !fuse_req_o));
    // R3: the key is forwarded only after a good completion
    assert_send_after_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_send_o |-> $past(q.state == ST_WAIT && fuse_done_i && fuse_ok_i));
    // R4: a completion with a bad result is a failed attempt
    assert_bad_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && fuse_done_i && !fuse_ok_i) |=> (key_clear_o && !key_send_o));
    // R5: the attempt number stays within the bound
    assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req_o |-> (q.tries != '0 && q.tries <= TRY_W'(MAX_TRIES)));
    // R6: an expired wait without completion fails the attempt
    assert_timeout_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !fuse_done_i && expired_i) |=> key_clear_o);

endmodule

// File: rtl/keyload_ctrl.sv
module keyload_ctrl
    import keyload_pkg::*;
#(
    parameter int unsigned MAX_TRIES  = 5,
    parameter int unsigned TIMEOUT_MS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             pg_ok_i,
    input  logic             ms_tick_i,
    output logic             fuse_req_o,
    input  logic             fuse_done_i,
    input  logic             fuse_ok_i,
    input  logic             fuse_err_i,
    output logic             key_clear_o,
    output logic             key_send_o,
    input  logic             sts_wr_i,
    input  logic [STS_W-1:0] sts_wdata_i,
    output logic [STS_W-1:0] sts_o,
    output logic             done_o,
    output logic             err_o
);
    logic             expired, restart, waiting, busy;
    logic [STS_W-1:0] seq_set, all_set;

    keyload_seq #(.MAX_TRIES(MAX_TRIES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .clear_i    (clear_i),
        .pg_ok_i    (pg_ok_i),
        .fuse_done_i(fuse_done_i),
        .fuse_ok_i  (fuse_ok_i),
        .fuse_err_i (fuse_err_i),
        .expired_i  (expired),
        .fuse_req_o (fuse_req_o),
        .key_clear_o(key_clear_o),
        .key_send_o (key_send_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .restart_o  (restart),
        .waiting_o  (waiting),
        .busy_o     (busy),
        .set_o      (seq_set)
    );

    keyload_tmr #(.TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .run_i    (waiting),
        .tick_i   (ms_tick_i),
        .expired_o(expired)
    );

    assign all_set = seq_set | (fuse_req_o ? (STS_W'(1) << SB_FZ_BUSY) : '0);

    keyload_sts u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sts_wr_i),
        .wdata_i (sts_wdata_i),
        .hw_clr_i(key_clear_o),
        .set_i   (all_set),
        .sts_o   (sts_o)
    );

    // R9: a command during a running sequence is flagged
    assert_busy_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (start_i || clear_i)) |=> sts_o[SB_IGNORED]);
    // R11: each load command marks the fuse busy bit
    assert_busy_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req_o |=> sts_o[SB_FZ_BUSY]);

endmodule

// File: tb/keyload_ctrl_test.sv
module keyload_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TRIES      = 5;
    localparam int TMO        = 3;
    localparam int TICK_DIV   = 4;
    localparam int FUSE_LAT   = 2;
    localparam int WATCH      = 100000;
    localparam int NCASE      = 7;

    // {pg_ok, failing attempts, fail by silence, fuse error flag, expected status}
    localparam logic [13:0] CASES [NCASE] = '{
        {1'b0, 3'd0, 1'b0, 1'b0, 8'h08},
        {1'b1, 3'd0, 1'b0, 1'b0, 8'hA3},
        {1'b1, 3'd2, 1'b0, 1'b0, 8'hA3},
        {1'b1, 3'd4, 1'b1, 1'b0, 8'hA3},
        {1'b1, 3'd5, 1'b0, 1'b0, 8'h10},
        {1'b1, 3'd5, 1'b1, 1'b0, 8'h10},
        {1'b1, 3'd1, 1'b0, 1'b1, 8'hE3}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start_i = 1'b0, clear_i = 1'b0, pg_ok_i = 1'b1, ms_tick_i = 1'b0;
    logic       fuse_done_i = 1'b0, fuse_ok_i = 1'b0, fuse_err_i = 1'b0;
    logic       sts_wr_i = 1'b0;
    logic [7:0] sts_wdata_i = '0;
    logic       fuse_req_o, key_clear_o, key_send_o, done_o, err_o;
    logic [7:0] sts_o;

    int total = 0, fails = 0, cyc = 0;
    int n_req = 0, n_clr = 0, n_send = 0, n_done = 0, n_err = 0;
    int req_base = 0, f_nfail = 0, f_tmo = 0, f_ferr = 0;
    int b_req, b_clr, b_send, b_done, b_err;

    keyload_ctrl #(.MAX_TRIES(TRIES), .TIMEOUT_MS(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
        .pg_ok_i(pg_ok_i), .ms_tick_i(ms_tick_i), .fuse_req_o(fuse_req_o),
        .fuse_done_i(fuse_done_i), .fuse_ok_i(fuse_ok_i), .fuse_err_i(fuse_err_i),
        .key_clear_o(key_clear_o), .key_send_o(key_send_o), .sts_wr_i(sts_wr_i),
        .sts_wdata_i(sts_wdata_i), .sts_o(sts_o), .done_o(done_o), .err_o(err_o)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // Fuse macro model, tick source, pulse counters and watchdog
    initial begin
        int cd = 0;
        bit ok_next = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCH) begin
                fails++; total++;
                $display("FAIL watchdog (all): actual %0d cycles expected below %0d", cyc, WATCH);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
            ms_tick_i = ((cyc % TICK_DIV) == 0);
            fuse_done_i = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    fuse_done_i = 1'b1;
                    fuse_ok_i   = ok_next;
                    fuse_err_i  = (f_ferr != 0);
                end
            end
            if (key_clear_o) n_clr++;
            if (key_send_o)  n_send++;
            if (done_o)      n_done++;
            if (err_o)       n_err++;
            if (fuse_req_o) begin
                n_req++;
                ok_next = ((n_req - req_base) > f_nfail);
                cd = (!ok_next && f_tmo != 0) ? 0 : FUSE_LAT;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic snap();
        b_req = n_req; b_clr = n_clr; b_send = n_send; b_done = n_done; b_err = n_err;
        req_base = n_req;
    endtask

    task automatic sts_write(input logic [7:0] v);
        @(negedge clk); sts_wr_i = 1'b1; sts_wdata_i = v;
        @(negedge clk); sts_wr_i = 1'b0; sts_wdata_i = '0;
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_end();
        int base = n_done + n_err;
        for (int i = 0; i < 400 && (n_done + n_err) == base; i++) @(negedge clk);
        for (int i = 0; i < 3; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk(sts_o == 8'h00, "R1 status", sts_o, 0);
        chk({fuse_req_o, key_clear_o, key_send_o, done_o, err_o} == 5'b0, "R1 outputs",
            {fuse_req_o, key_clear_o, key_send_o, done_o, err_o}, 0);

        for (int c = 0; c < NCASE; c++) begin
            logic [13:0] v = CASES[c];
            string tag;
            int e_req, e_clr, e_ok;
            pg_ok_i = v[13];
            f_nfail = int'(v[12:10]);
            f_tmo   = int'(v[9]);
            f_ferr  = int'(v[8]);
            if (!v[13])            tag = "R2";
            else if (f_nfail >= TRIES) tag = "R5";
            else if (f_tmo != 0)   tag = "R6";
            else if (f_ferr != 0)  tag = "R11";
            else if (f_nfail > 0)  tag = "R4";
            else                   tag = "R3";
            if (!v[13])                 begin e_req = 0;     e_clr = 0;       e_ok = 0; end
            else if (f_nfail >= TRIES)  begin e_req = TRIES; e_clr = TRIES;   e_ok = 0; end
            else                        begin e_req = f_nfail + 1; e_clr = f_nfail; e_ok = 1; end
            sts_write(8'hFF);
            snap();
            pulse_start();
            wait_end();
            chk(sts_o == v[7:0], {tag, " status"}, sts_o, v[7:0]);
            chk(n_req - b_req == e_req, {tag, " load commands"}, n_req - b_req, e_req);
            chk(n_clr - b_clr == e_clr, "R7 key clears", n_clr - b_clr, e_clr);
            chk((n_send - b_send == e_ok) && (n_done - b_done == e_ok) &&
                (n_err - b_err == 1 - e_ok), {tag, " outcome"},
                (n_send - b_send) * 16 + (n_done - b_done) * 4 + (n_err - b_err),
                e_ok * 20 + (1 - e_ok));
        end

        // R9: start during a running sequence is ignored and flagged
        pg_ok_i = 1'b1; f_nfail = 0; f_tmo = 0; f_ferr = 0;
        sts_write(8'hFF);
        snap();
        pulse_start();
        pulse_start();
        wait_end();
        chk(sts_o == 8'hA7, "R9 busy start status", sts_o, 8'hA7);
        chk(n_req - b_req == 1 && n_done - b_done == 1, "R9 busy start ignored",
            n_req - b_req, 1);

        // R8: write-one-to-clear touches only the bits written as one
        sts_write(8'h01);
        chk(sts_o == 8'hA6, "R8 w1c one bit", sts_o, 8'hA6);
        sts_write(8'h00);
        chk(sts_o == 8'hA6, "R8 w1c zero mask", sts_o, 8'hA6);

        // R10: idle clear command
        snap();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(n_clr - b_clr == 1, "R10 clear pulse", n_clr - b_clr, 1);
        chk(sts_o == 8'h04, "R10 clear status", sts_o, 8'h04);

        // R9: clear during a running sequence is ignored and flagged
        sts_write(8'hFF);
        snap();
        pulse_start();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        wait_end();
        chk(n_clr - b_clr == 0, "R9 busy clear ignored", n_clr - b_clr, 0);
        chk(sts_o == 8'hA7, "R9 busy clear status", sts_o, 8'hA7);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule